// File: doc/BRIEF.md
# Dual-Bus Ready Synchronizer

This block merges the completion signals of two system buses into one active-high ready line for a processor. Each bus contributes a ready bit that only counts while that bus's active-low address-enable is asserted; the two qualified bits are ORed into a single request. The request is then aligned to the processor clock before it reaches the processor, so that the processor always sees ready meet its setup and hold window.

The processor clock is not used directly. The block runs on a fast clock and is told where the processor clock's rising and falling events fall by two single-cycle strobes from the clock generator. A mode input picks the path for the request. In two-stage mode an asserting request is first captured on a rising event and confirmed on the following falling event. A deasserting request skips the first stage and takes effect at the next falling event. In single-stage mode the request is taken straight on each falling event. This suits devices that are known to meet setup time. The mode may be changed freely between bus cycles.

Top module: `ready_sync_top`

## Requirements
- R1: The qualified request is (rdy_a AND NOT aen_a_n) OR (rdy_b AND NOT aen_b_n); an unqualified ready bit has no effect on ready_out.
- R2: Stage one changes only in the fast-clock cycle after a clk_rise_en strobe, and ready_out changes only in the cycle after a clk_fall_en strobe. The two strobes are never high in the same cycle.
- R3: In two-stage mode (single_stage = 0), a request present at a rising strobe and still present at the next falling strobe makes ready_out high one cycle after that falling strobe.
- R4: In two-stage mode, ready_out stays low after a falling strobe if stage one did not hold the request. This covers a request that appeared after the last rising strobe and one that was withdrawn between the rising and falling strobes.
- R5: In either mode, a request that is low at a falling strobe makes ready_out low one cycle later.
- R6: In single-stage mode (single_stage = 1), ready_out after a falling strobe equals the qualified request at that strobe, whatever stage one holds.
- R7: A change of single_stage takes effect at the very next falling strobe.
- R8: While rst_n is low both stages are cleared and ready_out is low. The first falling strobe after reset cannot raise ready_out in two-stage mode unless a rising strobe came first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock driving all registers |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_rise_en | input | 1 | Strobe marking the processor clock rising event |
| clk_fall_en | input | 1 | Strobe marking the processor clock falling event |
| rdy_a | input | 1 | Ready from bus A, active high |
| aen_a_n | input | 1 | Address-enable qualifying rdy_a, active low |
| rdy_b | input | 1 | Ready from bus B, active high |
| aen_b_n | input | 1 | Address-enable qualifying rdy_b, active low |
| single_stage | input | 1 | 1 selects single-stage, 0 selects two-stage synchronization |
| ready_out | output | 1 | Synchronized ready to the processor, active high |

## Verification
All sixteen combinations of the four bus inputs are swept in single-stage mode. This separates a correct qualifier from one that drops the enable or swaps the polarity. Directed two-stage sequences are then applied: a request held across a rising and a falling event, a request that arrives just after the rising event, and a request that is withdrawn between the two events. These sequences tell the proper two-stage path apart from a single stage or from a symmetric deassert. A mode switch made between a rising and a falling event shows whether the new mode is taken at once. A long random run with a fixed seed then mixes request toggles, enable changes and mode flips against a bench reference model.

// File: rtl/ready_sync_pkg.sv
package ready_sync_pkg;

    // Register set of the synchronizer: first and second stage.
    typedef struct packed {
        logic stage1;
        logic stage2;
    } sync_regs_t;

    localparam sync_regs_t SYNC_REGS_RESET = '{stage1: 1'b0, stage2: 1'b0};

endpackage

// File: rtl/bus_ready_qualify.sv
module bus_ready_qualify #(
    parameter int N_BUS = 2
) (
    input  logic [N_BUS-1:0] bus_rdy,
    input  logic [N_BUS-1:0] bus_aen_n,
    output logic             req
);

    logic [N_BUS-1:0] qual;

    // Each bus ready counts only while its own enable is low (R1).
    for (genvar g = 0; g < N_BUS; g++) begin : g_qual
        assign qual[g] = bus_rdy[g] & ~bus_aen_n[g];
    end

    assign req = |qual;

endmodule

// File: rtl/ready_sync_stages.sv
module ready_sync_stages
    import ready_sync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise_en,
    input  logic fall_en,
    input  logic req,
    input  logic single_stage,
    output logic ready
);

    sync_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (rise_en) begin
            regs_d.stage1 = req;
        end
        if (fall_en) begin
            if (single_stage) begin
                regs_d.stage2 = req;
            end else begin
                // assert needs stage one; deassert goes straight through
                regs_d.stage2 = regs_q.stage1 & req;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= SYNC_REGS_RESET;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ready = regs_q.stage2;

    // R2: strobes are exclusive
    a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_en && fall_en));

    // R2: stage one moves only after a rising strobe
    a_r2_stage1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rise_en) |-> $stable(regs_q.stage1));

    // R2: output moves only after a falling strobe
    a_r2_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fall_en) |-> $stable(ready));

    // R4: two-stage mode cannot assert without stage one
    a_r4_needs_stage1: assert property (@(posedge clk) disable iff (!rst_n)
        fall_en && !single_stage && !regs_q.stage1 |=> !ready);

    // R5: deassert in one falling strobe
    a_r5_fast_drop: assert property (@(posedge clk) disable iff (!rst_n)
        fall_en && !req |=> !ready);

    // R6: single-stage mode follows the request
    a_r6_single_follow: assert property (@(posedge clk) disable iff (!rst_n)
        fall_en && single_stage |=> ready == $past(req));

endmodule

// File: rtl/ready_sync_top.sv
module ready_sync_top (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_rise_en,
    input  logic clk_fall_en,
    input  logic rdy_a,
    input  logic aen_a_n,
    input  logic rdy_b,
    input  logic aen_b_n,
    input  logic single_stage,
    output logic ready_out
);

    localparam int N_BUS = 2;

    logic             req;
    logic [N_BUS-1:0] bus_rdy;
    logic [N_BUS-1:0] bus_aen_n;

    assign bus_rdy   = {rdy_b, rdy_a};
    assign bus_aen_n = {aen_b_n, aen_a_n};

    bus_ready_qualify #(.N_BUS(N_BUS)) qual_i (
        .bus_rdy   (bus_rdy),
        .bus_aen_n (bus_aen_n),
        .req       (req)
    );

    ready_sync_stages stages_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rise_en      (clk_rise_en),
        .fall_en      (clk_fall_en),
        .req          (req),
        .single_stage (single_stage),
        .ready        (ready_out)
    );

endmodule

// File: tb/ready_sync_top_tb.sv
module ready_sync_top_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_rise_en = 1'b0;
    logic clk_fall_en = 1'b0;
    logic rdy_a = 1'b0, aen_a_n = 1'b1, rdy_b = 1'b0, aen_b_n = 1'b1;
    logic single_stage = 1'b0;
    logic ready_out;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    int ph = 2;              // strobe phase for the coming edge
    logic m1 = 1'b0, m2 = 1'b0;
    logic last_fall_mode = 1'b0;
    string tag = "R8";

    ready_sync_top dut_i (
        .clk(clk), .rst_n(rst_n), .clk_rise_en(clk_rise_en), .clk_fall_en(clk_fall_en),
        .rdy_a(rdy_a), .aen_a_n(aen_a_n), .rdy_b(rdy_b), .aen_b_n(aen_b_n),
        .single_stage(single_stage), .ready_out(ready_out)
    );

    always #5 clk = ~clk;

    function automatic logic qual_req(logic ra, logic ea_n, logic rb, logic eb_n);
        return (ra & ~ea_n) | (rb & ~eb_n);
    endfunction

    task automatic check(string t, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: ready_out=%b expected=%b at %0t", t, act, exp, $time);
        end
    endtask

    // One fast-clock cycle: update model at the edge, check at the negedge,
    // then drive the strobes for the next edge.
    task automatic tick();
        logic r, old1;
        @(posedge clk);
        r = qual_req(rdy_a, aen_a_n, rdy_b, aen_b_n);
        old1 = m1;
        if (!rst_n) begin
            m1 = 1'b0; m2 = 1'b0; tag = "R8";
        end else begin
            if (clk_rise_en) m1 = r;
            if (clk_fall_en) begin
                m2 = single_stage ? r : (old1 & r);
                if (single_stage != last_fall_mode) tag = "R7";
                else if (!r) tag = "R5";
                else if (single_stage) tag = "R6";
                else if (old1) tag = "R3";
                else tag = "R4";
                last_fall_mode = single_stage;
            end else begin
                tag = "R2";
            end
        end
        @(negedge clk);
        check(tag, ready_out, m2);
        ph = (ph + 1) % 3;
        clk_rise_en = (ph == 0);
        clk_fall_en = (ph == 1);
    endtask

    task automatic wait_phase(int p);
        while (ph != p) tick();
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));
        // R8: reset state
        repeat (5) tick();
        check("R8", ready_out, 1'b0);
        // R8: request present, release so the first strobe is a falling one
        rdy_a = 1'b1; aen_a_n = 1'b0;
        wait_phase(0);
        tick();                  // now ph == 1 (fall next)
        rst_n = 1'b1;
        tick();                  // falling strobe without prior rising
        check("R8", ready_out, 1'b0);
        repeat (6) tick();
        check("R3", ready_out, 1'b1);

        // R1: all 16 combinations in single-stage mode
        single_stage = 1'b1;
        for (int i = 0; i < 16; i++) begin
            wait_phase(2);
            {rdy_a, aen_a_n, rdy_b, aen_b_n} = 4'(i);
            repeat (3) tick();
            check("R1", ready_out, qual_req(rdy_a, aen_a_n, rdy_b, aen_b_n));
        end

        // R4: glitch between rising and falling strobe in two-stage mode
        single_stage = 1'b0; rdy_a = 0; rdy_b = 0; aen_a_n = 0; aen_b_n = 0;
        repeat (6) tick();
        wait_phase(0);
        rdy_b = 1'b1;
        tick();                  // rising strobe captures
        rdy_b = 1'b0;
        tick();                  // falling strobe sees no request
        check("R4", ready_out, 1'b0);

        // R4: late request, then asserts one processor cycle later
        wait_phase(1);
        rdy_a = 1'b1;
        tick();
        check("R4", ready_out, 1'b0);
        repeat (3) tick();
        check("R3", ready_out, 1'b1);
        // R5: deassert at next falling strobe
        wait_phase(1);
        rdy_a = 1'b0;
        tick();
        check("R5", ready_out, 1'b0);

        // R7: late request, mode switched before the falling strobe
        wait_phase(1);
        rdy_a = 1'b1; single_stage = 1'b1;
        tick();
        check("R7", ready_out, 1'b1);
        rdy_a = 1'b0; single_stage = 1'b0;
        repeat (3) tick();

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 3) == 0) rdy_a = 1'($urandom());
            if ($urandom_range(0, 3) == 0) rdy_b = 1'($urandom());
            if ($urandom_range(0, 7) == 0) aen_a_n = 1'($urandom());
            if ($urandom_range(0, 7) == 0) aen_b_n = 1'($urandom());
            if ($urandom_range(0, 9) == 0) single_stage = 1'($urandom());
            tick();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule